// File: doc/BRIEF.md
# March Memory Self-Test Sequencer

This block is a built-in self-test engine for a synchronous single-port RAM. A one-cycle start pulse makes it run a fixed list of march elements. Each element visits every address, in ascending or in descending order, and at each address it issues a short list of writes and read-compares. The engine drives the RAM address, write enable and write data. It compares the RAM read data one cycle after each read, because the RAM has one cycle of read latency. When the run ends it raises `done_o` and reports pass or fail, together with the address, the expected word and the read word of the first mismatch.

The element list is built to expose several fault classes. A rising ascending element and a falling descending element together catch address decoder aliasing. Two back-to-back reads catch a read that silently flips the cell. A write of the value already stored, followed by a read, catches a write that disturbs the cell. Every word is read both as its background and as the complement of its background. The run always makes a pass over a solid all-zeros background. An optional second pass repeats the list over a checkerboard background, so that neighbouring bits and neighbouring words hold opposite values. An optional pause of programmable length is inserted before each of the last two elements to expose cells that lose their charge. All three options are sampled on the start pulse.

Top module: `mbist_march_ctrl`

## Requirements
- R1: After reset and before any start, `busy_o`, `done_o`, `pass_o` and `ram_we_o` are 0, and the fail address, expected word and actual word outputs are 0.
- R2: The engine issues one RAM operation per cycle and has no idle cycles between elements. With no pause, a solid-only run keeps `busy_o` high for 11*DEPTH+1 cycles, and a run that adds the checkerboard pass keeps it high for 22*DEPTH+1 cycles. `done_o` rises in the cycle after the last compare.
- R3: The elements run in this order: ascending {write x}; ascending {read x, read x, write ~x}; descending {read ~x, write ~x, read ~x, write x}; ascending {read x, write ~x}; descending {read ~x}. In the solid pass x is 0 for every word, so a fault-free solid run leaves every word at all ones. In the checkerboard pass x is 0x55.. at even addresses and 0xAA.. at odd addresses, so a fault-free checkerboard run leaves even words at 0xAA.. and odd words at 0x55...
- R4: A cell whose first read returns the correct value but inverts the stored value fails on the second of the back-to-back reads. The reported expected word is the background and the reported actual word is its complement.
- R5: When a write to one address also overwrites a second, lower address, the descending element reports a failure at the lower address.
- R6: A cell that flips on a write of its current value fails on the read that follows the non-transition write in the descending element.
- R7: A short that ANDs two adjacent bits of one word passes a solid-only run and fails in the checkerboard pass.
- R8: When retention is enabled with a non-zero length N, the engine writes nothing for N cycles before each of the last two elements. Each pass then lasts 2N cycles longer. A cell that decays after a long idle time is reported only when the pause is enabled.
- R9: The fail address, expected word and actual word hold the first mismatch of the run, and later mismatches do not change them. `pass_o` is 0 after a run that saw any mismatch.
- R10: A start pulse while the run is in progress is ignored. Changes to the option inputs during a run have no effect on that run.
- R11: A new start clears the previous result. A fault-free rerun then ends with `pass_o` at 1 and the fail address at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted while idle or done |
| checker_en_i | input | 1 | Add the checkerboard background pass |
| retention_en_i | input | 1 | Enable the pause before the last two elements |
| pause_cycles_i | input | PAUSE_W | Pause length in clock cycles |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_we_o | output | 1 | RAM write enable; a read otherwise |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data, one cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_addr_o | output | ADDR_W | Address of first mismatch |
| fail_exp_o | output | DATA_W | Expected word at first mismatch |
| fail_act_o | output | DATA_W | Word read at first mismatch |

## Verification
The bench's RAM model can inject one kind of defect per run, and each defect is chosen so that exactly one feature of the element list catches it. A stuck bit is found on the first read of the background. An aliased write is found only by the descending read of the complement. A deceptive read flip is found only by the second of the paired reads. A disturbing non-transition write is found only by the read that follows it. A bit-AND short is found only in the checkerboard pass. A leaky cell is found only with the pause enabled. Fault-free runs over both backgrounds confirm the exact busy length and the final memory image. A stuck bit in two different cells confirms that only the first mismatch is kept. A start pulse and an option change in the middle of a run confirm that neither has any effect.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_DRAIN,
        ST_DONE
    } mb_state_t;

    // one RAM operation: write or read-compare, on background or complement
    typedef struct packed {
        logic wr;
        logic inv;
    } mb_op_t;

    // one march element
    typedef struct packed {
        logic            down;   // descending sweep
        logic            hold;   // retention pause before this element
        logic [1:0]      last;   // index of last op
        mb_op_t [3:0]    ops;
    } mb_elem_t;

    localparam int NUM_ELEM = 5;
    localparam logic [63:0] ALT_WORD = 64'h5555_5555_5555_5555;

    function automatic mb_elem_t elem_at(input logic [2:0] idx);
        mb_elem_t e;
        e = '0;
        case (idx)
            3'd0: begin
                e.last   = 2'd0;
                e.ops[0] = '{wr: 1'b1, inv: 1'b0};
            end
            3'd1: begin
                e.last   = 2'd2;
                e.ops[0] = '{wr: 1'b0, inv: 1'b0};
                e.ops[1] = '{wr: 1'b0, inv: 1'b0};
                e.ops[2] = '{wr: 1'b1, inv: 1'b1};
            end
            3'd2: begin
                e.down   = 1'b1;
                e.last   = 2'd3;
                e.ops[0] = '{wr: 1'b0, inv: 1'b1};
                e.ops[1] = '{wr: 1'b1, inv: 1'b1};
                e.ops[2] = '{wr: 1'b0, inv: 1'b1};
                e.ops[3] = '{wr: 1'b1, inv: 1'b0};
            end
            3'd3: begin
                e.hold   = 1'b1;
                e.last   = 2'd1;
                e.ops[0] = '{wr: 1'b0, inv: 1'b0};
                e.ops[1] = '{wr: 1'b1, inv: 1'b1};
            end
            default: begin
                e.down   = 1'b1;
                e.hold   = 1'b1;
                e.last   = 2'd0;
                e.ops[0] = '{wr: 1'b0, inv: 1'b1};
            end
        endcase
        return e;
    endfunction

    function automatic logic elem_down(input logic [2:0] idx);
        mb_elem_t e;
        e = elem_at(idx);
        return e.down;
    endfunction

    function automatic logic elem_hold(input logic [2:0] idx);
        mb_elem_t e;
        e = elem_at(idx);
        return e.hold;
    endfunction

    function automatic logic [1:0] elem_last(input logic [2:0] idx);
        mb_elem_t e;
        e = elem_at(idx);
        return e.last;
    endfunction

    function automatic mb_op_t elem_op(input logic [2:0] idx, input logic [1:0] opi);
        mb_elem_t e;
        e = elem_at(idx);
        return e.ops[opi];
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              down_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic              down_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            down_q <= 1'b0;
            addr_q <= '0;
        end else if (load_i) begin
            down_q <= down_i;
            addr_q <= down_i ? '1 : '0;
        end else if (step_i) begin
            addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = down_q ? (addr_q == '0) : (addr_q == '1);

    // the sequencer must never step past the end of a sweep
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |-> !last_o);

endmodule

// File: rtl/mbist_pause_timer.sv
module mbist_pause_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             run_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q <= CNT_W'(1));

    // once expired the timer stays expired until reloaded
    p_expire_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !load_i) |=> expire_o);

endmodule

// File: rtl/mbist_fail_capture.sv
module mbist_fail_capture #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] act_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] exp_o,
    output logic [DATA_W-1:0] act_o
);
    logic              fail_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic [DATA_W-1:0] act_q;
    logic              mismatch;

    assign mismatch = valid_i && (act_i != exp_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
            act_q  <= '0;
        end else if (mismatch && !fail_q) begin
            fail_q <= 1'b1;
            addr_q <= addr_i;
            exp_q  <= exp_i;
            act_q  <= act_i;
        end
    end

    assign fail_o = fail_q;
    assign addr_o = addr_q;
    assign exp_o  = exp_q;
    assign act_o  = act_q;

    p_first_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !clear_i) |=> (fail_q && $stable(addr_q) && $stable(exp_q) && $stable(act_q)));

    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !fail_q);

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int PAUSE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               checker_en_i,
    input  logic               retention_en_i,
    input  logic [PAUSE_W-1:0] pause_cycles_i,
    output logic [ADDR_W-1:0]  ram_addr_o,
    output logic               ram_we_o,
    output logic [DATA_W-1:0]  ram_wdata_o,
    input  logic [DATA_W-1:0]  ram_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic [ADDR_W-1:0]  fail_addr_o,
    output logic [DATA_W-1:0]  fail_exp_o,
    output logic [DATA_W-1:0]  fail_act_o
);
    localparam logic [DATA_W-1:0] BG_EVEN  = ALT_WORD[DATA_W-1:0];
    localparam logic [DATA_W-1:0] BG_ODD   = ~BG_EVEN;
    localparam logic [2:0]        ELEM_END = 3'(NUM_ELEM - 1);

    mb_state_t          state_q;
    logic [2:0]         elem_q;
    logic [1:0]         op_q;
    logic               pass_q;
    logic               chk_q, ret_q;
    logic [PAUSE_W-1:0] pause_q;

    logic               rd_v_q;
    logic [ADDR_W-1:0]  rd_addr_q;
    logic [DATA_W-1:0]  rd_exp_q;

    mb_op_t             op;
    logic               run, last_op, elem_end, wrap, launch, to_drain, begin_elem;
    logic [2:0]         tgt_elem;
    logic               tgt_pass, tgt_hold, ret_now;
    logic [PAUSE_W-1:0] pause_now;
    logic [DATA_W-1:0]  bg, exp_word;
    logic [ADDR_W-1:0]  ag_addr;
    logic               ag_last, ag_step, pause_done, fail;

    always_comb begin
        op         = elem_op(elem_q, op_q);
        run        = (state_q == ST_RUN);
        last_op    = (op_q == elem_last(elem_q));
        elem_end   = run && last_op && ag_last;
        wrap       = (elem_q == ELEM_END);
        launch     = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;
        to_drain   = elem_end && wrap && !(!pass_q && chk_q);
        begin_elem = launch || (elem_end && !to_drain);
        tgt_elem   = (launch || wrap) ? 3'd0 : elem_q + 3'd1;
        tgt_pass   = launch ? 1'b0 : (wrap ? 1'b1 : pass_q);
        ret_now    = launch ? retention_en_i : ret_q;
        pause_now  = launch ? pause_cycles_i : pause_q;
        tgt_hold   = elem_hold(tgt_elem) && ret_now && (pause_now != '0);
        ag_step    = run && last_op && !ag_last;
        bg         = pass_q ? (ag_addr[0] ? BG_ODD : BG_EVEN) : '0;
        exp_word   = op.inv ? ~bg : bg;
    end

    mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load_i (begin_elem),
        .down_i (elem_down(tgt_elem)),
        .step_i (ag_step),
        .addr_o (ag_addr),
        .last_o (ag_last)
    );

    mbist_pause_timer #(.CNT_W(PAUSE_W)) u_pause (
        .clk      (clk),
        .rst      (rst),
        .load_i   (begin_elem && tgt_hold),
        .len_i    (pause_now),
        .run_i    (state_q == ST_PAUSE),
        .expire_o (pause_done)
    );

    mbist_fail_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fail (
        .clk     (clk),
        .rst     (rst),
        .clear_i (launch),
        .valid_i (rd_v_q),
        .addr_i  (rd_addr_q),
        .exp_i   (rd_exp_q),
        .act_i   (ram_rdata_i),
        .fail_o  (fail),
        .addr_o  (fail_addr_o),
        .exp_o   (fail_exp_o),
        .act_o   (fail_act_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            op_q      <= '0;
            pass_q    <= 1'b0;
            chk_q     <= 1'b0;
            ret_q     <= 1'b0;
            pause_q   <= '0;
            rd_v_q    <= 1'b0;
            rd_addr_q <= '0;
            rd_exp_q  <= '0;
        end else begin
            // read pipeline: compare one cycle after the read is issued
            rd_v_q    <= run && !op.wr;
            rd_addr_q <= ag_addr;
            rd_exp_q  <= exp_word;

            case (state_q)
                ST_RUN: begin
                    op_q <= last_op ? 2'd0 : op_q + 2'd1;
                    if (to_drain) state_q <= ST_DRAIN;
                end
                ST_PAUSE: if (pause_done) state_q <= ST_RUN;
                ST_DRAIN: state_q <= ST_DONE;
                default:  ;
            endcase

            if (launch) begin
                chk_q   <= checker_en_i;
                ret_q   <= retention_en_i;
                pause_q <= pause_cycles_i;
            end

            if (begin_elem) begin
                elem_q  <= tgt_elem;
                pass_q  <= tgt_pass;
                op_q    <= 2'd0;
                state_q <= tgt_hold ? ST_PAUSE : ST_RUN;
            end
        end
    end

    assign ram_addr_o  = ag_addr;
    assign ram_we_o    = run && op.wr;
    assign ram_wdata_o = exp_word;
    assign busy_o      = (state_q == ST_RUN) || (state_q == ST_PAUSE) || (state_q == ST_DRAIN);
    assign done_o      = (state_q == ST_DONE);
    assign pass_o      = done_o && !fail;

    // address stays put while the ops of one address are issued
    p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !last_op) |=> (ram_addr_o == $past(ram_addr_o)));

    p_drain_then_done_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |=> done_o);

    p_quiet_pause_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAUSE) |-> !ram_we_o);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (run && start_i && !elem_end) |=> (busy_o && $stable(chk_q)));

endmodule

// File: tb/test_mbist_march_ctrl.sv
module test_mbist_march_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PW = 24;
    localparam int DEPTH = 1 << AW;
    localparam int LEAK_LIMIT = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          chk_en = 1'b0;
    logic          ret_en = 1'b0;
    logic [PW-1:0] pause_len = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;
    logic          busy, done, pass;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_exp, f_act;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // fault injection controls of the RAM model
    logic stuck_en = 0, alias_en = 0, drdf_en = 0, wdf_en = 0, bridge_en = 0, leak_en = 0;
    logic [DW-1:0] mem [DEPTH];
    int leak_touch = 0;

    always #5 clk = ~clk;

    mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAUSE_W(PW)) i_mbist_march_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .checker_en_i(chk_en),
        .retention_en_i(ret_en), .pause_cycles_i(pause_len),
        .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
        .ram_rdata_i(ram_rdata), .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_addr_o(f_addr), .fail_exp_o(f_exp), .fail_act_o(f_act)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // synchronous RAM model, one-cycle read latency, optional defects
    always @(posedge clk) begin
        logic [DW-1:0] d;
        if (ram_we) begin
            d = ram_wdata;
            if (stuck_en && (ram_addr == 4'd5 || ram_addr == 4'd12)) d[2] = 1'b1;
            if (bridge_en && ram_addr == 4'd6) begin
                d[0] = ram_wdata[0] & ram_wdata[1];
                d[1] = ram_wdata[0] & ram_wdata[1];
            end
            if (wdf_en && ram_addr == 4'd11 && mem[11] == ram_wdata) d = ~ram_wdata;
            mem[ram_addr] <= d;
            if (alias_en && ram_addr == 4'd9) mem[3] <= d;
            if (ram_addr == 4'd2) leak_touch <= cyc;
        end else begin
            if (leak_en && ram_addr == 4'd2 && (cyc - leak_touch) > LEAK_LIMIT) begin
                ram_rdata <= '0;
                mem[2]    <= '0;
            end else begin
                ram_rdata <= mem[ram_addr];
            end
            if (drdf_en && ram_addr == 4'd7) mem[7] <= ~mem[7];
            if (ram_addr == 4'd2) leak_touch <= cyc;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_faults();
        stuck_en = 0; alias_en = 0; drdf_en = 0; wdf_en = 0; bridge_en = 0; leak_en = 0;
    endtask

    task automatic fill(input logic [DW-1:0] v);
        for (int i = 0; i < DEPTH; i++) mem[i] = v;
        leak_touch = cyc;
    endtask

    // start a run; optionally poke start and the checker option at busy cycle poke
    task automatic run_march(input logic c, input logic r, input int p, input int poke, output int bc);
        int guard;
        chk_en = c; ret_en = r; pause_len = PW'(p);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        bc = 0; guard = 0;
        while (!done && guard < 5000) begin
            if (busy) bc++;
            if (bc == poke) begin start = 1'b1; chk_en = ~chk_en; end
            else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(done, "R2 run finishes", int'(done), 1);
    endtask

    task automatic t_reset();
        check(!busy && !done && !pass && !ram_we, "R1 idle outputs",
              int'({busy, done, pass, ram_we}), 0);
        check(f_addr == 0 && f_exp == 0 && f_act == 0, "R1 result cleared",
              int'({f_addr, f_exp, f_act}), 0);
    endtask

    task automatic t_solid_clean();
        int bc; logic ok;
        clear_faults(); fill(8'h00);
        run_march(0, 0, 0, 20, bc);
        check(bc == 11 * DEPTH + 1, "R2 solid busy length", bc, 11 * DEPTH + 1);
        check(pass, "R2 solid pass", int'(pass), 1);
        check(bc == 11 * DEPTH + 1 && pass, "R10 start and option change ignored mid-run", bc, 11 * DEPTH + 1);
        ok = 1;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) ok = 0;
        check(ok, "R3 solid final image all ones", int'(mem[0]), 8'hFF);
        chk_en = 0;
    endtask

    task automatic t_checker_clean();
        int bc; logic ok;
        clear_faults(); fill(8'h00);
        run_march(1, 0, 0, -1, bc);
        check(bc == 22 * DEPTH + 1, "R2 checker busy length", bc, 22 * DEPTH + 1);
        check(pass, "R3 checker pass", int'(pass), 1);
        ok = 1;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != ((i % 2 == 0) ? 8'hAA : 8'h55)) ok = 0;
        check(ok, "R3 checker final image", int'(mem[0]), 8'hAA);
    endtask

    task automatic t_fail(input string tag, input logic c, input logic r, input int p,
                          input int ea, input int ee, input int ex);
        int bc;
        run_march(c, r, p, -1, bc);
        check(!pass, {tag, " pass low"}, int'(pass), 0);
        check(f_addr == AW'(ea), {tag, " address"}, int'(f_addr), ea);
        check(f_exp == DW'(ee) && f_act == DW'(ex), {tag, " words"},
              int'({f_exp, f_act}), (ee << 8) | ex);
    endtask

    task automatic t_stuck();
        clear_faults(); fill(8'h00); stuck_en = 1;
        t_fail("R9 first of two stuck cells", 0, 0, 0, 5, 8'h00, 8'h04);
    endtask

    task automatic t_alias();
        clear_faults(); fill(8'h00); alias_en = 1;
        t_fail("R5 decoder alias", 0, 0, 0, 3, 8'hFF, 8'h00);
    endtask

    task automatic t_drdf();
        clear_faults(); fill(8'h00); drdf_en = 1;
        t_fail("R4 deceptive read", 0, 0, 0, 7, 8'h00, 8'hFF);
    endtask

    task automatic t_wdf();
        clear_faults(); fill(8'hFF); wdf_en = 1;
        t_fail("R6 write disturb", 0, 0, 0, 11, 8'hFF, 8'h00);
    endtask

    task automatic t_bridge();
        int bc;
        clear_faults(); fill(8'h00); bridge_en = 1;
        run_march(0, 0, 0, -1, bc);
        check(pass, "R7 bridge unseen by solid pass", int'(pass), 1);
        t_fail("R7 bridge in checkerboard", 1, 0, 0, 6, 8'h55, 8'h54);
    endtask

    task automatic t_leak();
        int bc;
        clear_faults(); fill(8'h00); leak_en = 1;
        run_march(0, 0, 0, -1, bc);
        check(pass, "R8 leak unseen without pause", int'(pass), 1);
        t_fail("R8 leak with pause", 0, 1, 250, 2, 8'hFF, 8'h00);
        clear_faults(); fill(8'h00);
        run_march(0, 1, 250, -1, bc);
        check(bc == 11 * DEPTH + 1 + 500, "R8 pause length", bc, 11 * DEPTH + 1 + 500);
    endtask

    task automatic t_restart();
        int bc;
        clear_faults(); fill(8'h00); stuck_en = 1;
        run_march(0, 0, 0, -1, bc);
        check(!pass, "R11 failing run first", int'(pass), 0);
        clear_faults();
        run_march(0, 0, 0, -1, bc);
        check(pass && f_addr == 0, "R11 rerun clears result", int'({pass, f_addr}), 32'h10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill(8'h00);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_solid_clean();
        t_checker_clean();
        t_stuck();
        t_alias();
        t_drdf();
        t_wdf();
        t_bridge();
        t_leak();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule